// File: doc/BRIEF.md
# Strobe-Domain Read Capture FIFO

This block carries read data that arrives on a bursty, non-continuous data strobe into a free-running fabric clock of the same frequency. Each strobe group owns one pointer controller. Its 3-bit write pointer runs on the group's strobe and its 3-bit read pointer runs on the fabric clock. Both pointers are shared by every data lane of the group, so each lane's eight-entry store is written and read in lockstep with its neighbours.

Reads start at a fixed latency after a fabric-side read window opens. Every group reads under the same window, which removes any small arrival skew between groups: words that were written at different strobe phases appear together on the fabric side. The write pointer is passed to the fabric domain in Gray code through a two-stage synchronizer. That copy is used to confirm that a read never reaches a slot that has not yet been written.

Top module: `rcf_capture`

## Requirements
- R1: While reset is held and after it is released, `dout_valid` is 0 and `dout` is all zeros until the first read.
- R2: Each rising edge of a group's strobe writes every lane word of that group into one of eight slots, chosen by a 3-bit write pointer that then increments modulo 8. A burst longer than eight words wraps around and stays correct.
- R3: The write pointer changes only on strobe edges. While the strobe is idle between bursts it holds its value, so the next burst continues the stream without a gap.
- R4: If `rd_window` is first sampled high at fabric edge n, then `dout_valid` is first high after fabric edge n+4 (RD_LAT = 4). Each sampled-high window cycle yields exactly one valid output cycle.
- R5: On each fabric cycle with `dout_valid` high, each lane presents the next word in the order in which it was written, one word per cycle.
- R6: All lanes of a group present words of the same write index in the same cycle. Lane l of group g is bits [(g*LANES+l)*DATA_W +: DATA_W] of both `din` and `dout`.
- R7: Groups whose strobes arrive up to about 1.25 fabric periods apart present words of the same index in the same output cycle.
- R8: After `rd_window` falls, `dout_valid` stays high for 4 more cycles and then drops. While `dout_valid` is low, `dout` holds its last value.
- R9: The write pointer reaches the fabric domain in Gray code through two flip-flops. The synchronized copy changes by at most one bit per fabric cycle, and it differs from the read pointer whenever a read is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fab_clk | input | 1 | Continuous fabric clock; read side |
| rst | input | 1 | Shared active-high reset; released while the strobes are idle |
| strb_clk | input | GROUPS | One data strobe per group; write clock, toggles only during bursts |
| din | input | GROUPS*LANES*DATA_W | Lane words captured on each strobe's rising edge |
| rd_window | input | 1 | Fabric-domain read window; one cycle high per expected word |
| dout | output | GROUPS*LANES*DATA_W | Realigned lane words, fabric domain |
| dout_valid | output | 1 | High in each cycle that carries a fresh word set on `dout` |

## Verification
The critical overlap is a strobe edge that writes a new slot in the same fabric cycle that the read side takes an older slot, while the Gray pointer copy is also changing. The bench provokes this with overlapping windows and bursts on two groups, using strobe offsets of 1 ns and 9 ns against an 8 ns fabric period. One burst is 12 words long, so the write pointer wraps while reads are in progress. A scoreboard queue of sequence numbers gives the expected word for every lane of both groups, and every valid fabric cycle is compared against it.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    localparam int PTR_W = 3;
    localparam int DEPTH = 1 << PTR_W;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        ptr_t bin;
        ptr_t gray;
    } ptr_pair_t;

    function automatic ptr_t bin2gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/rcf_sync2.sv
module rcf_sync2 #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/rcf_wr_ptr.sv
module rcf_wr_ptr
    import rcf_pkg::*;
(
    input  logic      strb_clk,
    input  logic      rst,
    output ptr_pair_t wp
);
    ptr_t bin_q;
    ptr_t gray_q;
    ptr_t bin_nx;
    logic seen_q;

    assign bin_nx = bin_q + ptr_t'(1);

    // Strobe is idle during reset, so this domain resets asynchronously.
    always_ff @(posedge strb_clk or posedge rst) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
            seen_q <= 1'b0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin2gray(bin_nx);
            seen_q <= 1'b1;
        end
    end

    assign wp = '{bin: bin_q, gray: gray_q};

    // R2: one slot per strobe edge, modulo eight
    assert_wptr_step_R2: assert property (@(posedge strb_clk) disable iff (rst)
        seen_q |=> (wp.bin == $past(wp.bin) + ptr_t'(1)));
endmodule

// File: rtl/rcf_rd_ptr.sv
module rcf_rd_ptr
    import rcf_pkg::*;
(
    input  logic fab_clk,
    input  logic rst,
    input  logic rd_en,
    input  ptr_t wr_gray,
    output ptr_t rd_bin
);
    ptr_t wg_sync;
    ptr_t rd_q;

    rcf_sync2 #(.W(PTR_W)) u_wsync (
        .clk (fab_clk),
        .rst (rst),
        .d   (wr_gray),
        .q   (wg_sync)
    );

    always_ff @(posedge fab_clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_q + ptr_t'(1);
        end
    end

    assign rd_bin = rd_q;

    assert_gray_step_R9: assert property (@(posedge fab_clk) disable iff (rst)
        $countones(wg_sync ^ $past(wg_sync)) <= 1);

    assert_not_empty_R9: assert property (@(posedge fab_clk) disable iff (rst)
        rd_en |-> (gray2bin(wg_sync) != rd_q));

    assert_rptr_step_R5: assert property (@(posedge fab_clk) disable iff (rst)
        rd_en |=> (rd_q == $past(rd_q) + ptr_t'(1)));

    assert_rptr_hold_R8: assert property (@(posedge fab_clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/rcf_lane_store.sv
module rcf_lane_store
    import rcf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              strb_clk,
    input  ptr_t              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  ptr_t              rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge strb_clk) begin
        mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rcf_win_delay.sv
module rcf_win_delay #(
    parameter int RD_LAT = 4
) (
    input  logic fab_clk,
    input  logic rst,
    input  logic rd_window,
    output logic rd_en
);
    logic [RD_LAT-1:0] sr;

    generate
        if (RD_LAT == 1) begin : g_single
            always_ff @(posedge fab_clk) begin
                if (rst) sr <= '0;
                else     sr <= rd_window;
            end
        end else begin : g_chain
            always_ff @(posedge fab_clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[RD_LAT-2:0], rd_window};
            end
        end
    endgenerate

    assign rd_en = sr[RD_LAT-1];
endmodule

// File: rtl/rcf_group.sv
module rcf_group
    import rcf_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DATA_W = 8
) (
    input  logic                    strb_clk,
    input  logic                    fab_clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic [LANES*DATA_W-1:0] din,
    output logic [LANES*DATA_W-1:0] dout
);
    ptr_pair_t                 wp;
    ptr_t                      rptr;
    logic [LANES*DATA_W-1:0]   lane_rd;
    logic [LANES*DATA_W-1:0]   dout_q;

    rcf_wr_ptr u_wp (
        .strb_clk (strb_clk),
        .rst      (rst),
        .wp       (wp)
    );

    rcf_rd_ptr u_rp (
        .fab_clk (fab_clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_gray (wp.gray),
        .rd_bin  (rptr)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rcf_lane_store #(.DATA_W(DATA_W)) u_st (
            .strb_clk (strb_clk),
            .wr_addr  (wp.bin),
            .wr_data  (din[l*DATA_W +: DATA_W]),
            .rd_addr  (rptr),
            .rd_data  (lane_rd[l*DATA_W +: DATA_W])
        );
    end

    always_ff @(posedge fab_clk) begin
        if (rst) begin
            dout_q <= '0;
        end else if (rd_en) begin
            dout_q <= lane_rd;
        end
    end

    assign dout = dout_q;
endmodule

// File: rtl/rcf_capture.sv
module rcf_capture
    import rcf_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int LANES  = 4,
    parameter int DATA_W = 8,
    parameter int RD_LAT = 4
) (
    input  logic                           fab_clk,
    input  logic                           rst,
    input  logic [GROUPS-1:0]              strb_clk,
    input  logic [GROUPS*LANES*DATA_W-1:0] din,
    input  logic                           rd_window,
    output logic [GROUPS*LANES*DATA_W-1:0] dout,
    output logic                           dout_valid
);
    localparam int GRP_W = LANES * DATA_W;

    logic rd_en;
    logic valid_q;

    rcf_win_delay #(.RD_LAT(RD_LAT)) u_win (
        .fab_clk   (fab_clk),
        .rst       (rst),
        .rd_window (rd_window),
        .rd_en     (rd_en)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        rcf_group #(.LANES(LANES), .DATA_W(DATA_W)) u_grp (
            .strb_clk (strb_clk[g]),
            .fab_clk  (fab_clk),
            .rst      (rst),
            .rd_en    (rd_en),
            .din      (din[g*GRP_W +: GRP_W]),
            .dout     (dout[g*GRP_W +: GRP_W])
        );
    end

    always_ff @(posedge fab_clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= rd_en;
    end

    assign dout_valid = valid_q;

    assert_dout_hold_R8: assert property (@(posedge fab_clk) disable iff (rst)
        !rd_en |=> $stable(dout));
endmodule

// File: tb/sim_rcf_capture.sv
module sim_rcf_capture;
    localparam int G  = 2;
    localparam int L  = 4;
    localparam int W  = 8;
    localparam int VW = G * L * W;

    logic          fab_clk = 1'b0;
    logic          rst     = 1'b1;
    logic [G-1:0]  strb    = '0;
    logic [VW-1:0] din     = '0;
    logic          rd_window = 1'b0;
    logic [VW-1:0] dout;
    logic          dout_valid;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    int seq_next = 0;
    logic [VW-1:0] last_dout = '0;
    bit done = 1'b0;

    always #4 fab_clk = ~fab_clk;   // 125 MHz

    rcf_capture #(.GROUPS(G), .LANES(L), .DATA_W(W), .RD_LAT(4)) u0 (
        .fab_clk    (fab_clk),
        .rst        (rst),
        .strb_clk   (strb),
        .din        (din),
        .rd_window  (rd_window),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    function automatic logic [VW-1:0] exp_vec(int s);
        logic [VW-1:0] v;
        for (int g = 0; g < G; g++) begin
            for (int l = 0; l < L; l++) begin
                v[(g*L+l)*W +: W] = {g[0], l[1:0], s[4:0]};
            end
        end
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic drive_grp(int g, int off, int n, int base);
        logic [VW-1:0] v;
        #(off);
        for (int i = 0; i < n; i++) begin
            v = exp_vec(base + i);
            din[g*L*W +: L*W] = v[g*L*W +: L*W];
            #2 strb[g] = 1'b1;
            #4 strb[g] = 1'b0;
            #2;
        end
    endtask

    // Window of n cycles plus n strobe edges per group; R4 and R8 timing checks.
    task automatic run_burst(int n);
        int base;
        base = seq_next;
        seq_next += n;
        for (int i = 0; i < n; i++) exp_q.push_back(base + i);
        rd_window = 1'b1;
        fork
            drive_grp(0, 1, n, base);
            drive_grp(1, 9, n, base);
            begin
                repeat (4) @(negedge fab_clk);
                chk(dout_valid == 1'b0, "R4 valid early", {{(VW-1){1'b0}}, dout_valid}, '0);
                @(negedge fab_clk);
                chk(dout_valid == 1'b1, "R4 valid at latency", {{(VW-1){1'b0}}, dout_valid}, 1);
                repeat (n - 5) @(negedge fab_clk);
                rd_window = 1'b0;
                repeat (4) @(negedge fab_clk);
                chk(dout_valid == 1'b1, "R8 valid tail", {{(VW-1){1'b0}}, dout_valid}, 1);
                @(negedge fab_clk);
                chk(dout_valid == 1'b0, "R8 valid drop", {{(VW-1){1'b0}}, dout_valid}, '0);
            end
        join
        repeat (6) @(negedge fab_clk);
    endtask

    // Scoreboard monitor
    always @(negedge fab_clk) begin
        if (!rst && !done) begin
            if (dout_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected word", dout, '0);
                end else begin
                    automatic int s = exp_q.pop_front();
                    chk(dout == exp_vec(s), "R2 R3 R5 R6 R7 R9 data", dout, exp_vec(s));
                end
                last_dout = dout;
            end else begin
                chk(dout == last_dout, "R8 hold", dout, last_dout);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge fab_clk);
        chk(dout_valid == 1'b0, "R1 valid in reset", {{(VW-1){1'b0}}, dout_valid}, '0);
        rst = 1'b0;
        repeat (3) @(negedge fab_clk);
        chk(dout_valid == 1'b0, "R1 valid after reset", {{(VW-1){1'b0}}, dout_valid}, '0);
        chk(dout == '0, "R1 dout after reset", dout, '0);
        run_burst(5);
        run_burst(12);   // wraps the 3-bit pointers (R2)
        repeat (10) @(negedge fab_clk);   // idle strobe, pointer held (R3)
        run_burst(6);
        chk(exp_q.size() == 0, "R5 all words delivered", VW'(exp_q.size()), '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule